// File: doc/BRIEF.md
# Keyed Watchdog Timer Controller

This block is a watchdog for a small byte-wide I/O bus. It has two write-only byte registers. The configuration register holds the enable bit, a timeout select and a halt-mode field. The key register takes command bytes that restart the count, stop the watchdog, or arm a one-shot change of the halt mode. The count advances on a prescaled time-base tick supplied from outside. When the selected number of ticks passes without a restart, the block raises an active-high reset output for a fixed number of clocks and then starts counting again from zero.

Stopping the watchdog takes two steps. Software first writes the configuration register with the enable bit low, and then writes the stop key. Each step on its own leaves the watchdog running. The halt mode is only passed out as a field for the power-management logic. The block does nothing else with it.

Top module: `wdt_keyed_top`

## Requirements
- R1: After a synchronous reset the watchdog is running with timeout code 3, the halt mode is run (code 3), `wdt_rst` is low and the count is zero.
- R2: A write to the configuration address (default F0h) takes effect only when data bits 2:0 equal 011. It then loads the enable bit from bit 7 and the timeout code from bits 6:5. A write with any other value in bits 2:0 changes nothing.
- R3: While running, `wdt_rst` rises on the clock after the tick that completes 2^(BASE_LOG2 + 2*code) ticks since the count was last zero. With the default BASE_LOG2 of 16 this gives 2^16, 2^18, 2^20 or 2^22 ticks for codes 0 to 3.
- R4: The count advances only in cycles where `tick` is high.
- R5: Writing 4Eh to the key address (default F1h) sets the count back to zero. If it coincides with the final tick, it prevents expiry.
- R6: Clearing the enable bit alone leaves the watchdog running. Writing B1h to the key address stops it only while the stored enable bit is 0. B1h sent while the enable bit is 1 has no effect.
- R7: A valid configuration write with bit 7 set starts a stopped watchdog, counting from zero.
- R8: `halt_mode` (0 idle 1, 1 idle 2, 2 stop, 3 run) takes data bits 4:3 only on the first valid configuration write after a DBh key. That write consumes the authorization. Any other configuration write keeps the field unchanged.
- R9: Key-address bytes other than 4Eh, B1h and DBh have no effect except to cancel a pending DBh authorization. 4Eh and B1h leave a pending authorization in place.
- R10: On expiry `wdt_rst` stays high for exactly PULSE_LEN clocks (default 16). During the pulse the count is held at zero and key writes do not extend the pulse.
- R11: Writes to addresses other than the two register addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Write strobe, one cycle per byte written |
| io_addr | input | 8 | I/O address of the write |
| io_wdata | input | 8 | Write data |
| tick | input | 1 | Prescaled time-base tick, one clock wide |
| wdt_rst | output | 1 | Active-high reset pulse on expiry |
| halt_mode | output | 2 | Current halt/power-down mode field |

## Verification
A register write sampled at clock edge k changes the stored state after that edge. The count and the pulse counter act on the configuration and run state held before edge k. So `halt_mode` is due one clock after its write, and `wdt_rst` rises one clock after the final tick. The bench drives every input at the falling edge. It advances its own cycle model at the rising edge and compares both outputs at the next falling edge, so every comparison lands in the cycle the result is due. The directed timing checks count ticks from a known zero count, which is set by a restart key or a completed pulse. They then sample just before and just after the expected edge. Pulse length is measured by counting high cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [7:0] KEY_KICK  = 8'h4E;
    localparam logic [7:0] KEY_STOP  = 8'hB1;
    localparam logic [7:0] KEY_MODE  = 8'hDB;
    localparam logic [2:0] CFG_MAGIC = 3'b011;

    typedef enum logic [1:0] {
        HM_IDLE1 = 2'd0,
        HM_IDLE2 = 2'd1,
        HM_STOP  = 2'd2,
        HM_RUN   = 2'd3
    } halt_mode_e;

    typedef struct packed {
        logic       en;
        logic [1:0] span;
        halt_mode_e halt;
    } wdt_cfg_t;

    localparam wdt_cfg_t CFG_RESET = '{en: 1'b1, span: 2'd3, halt: HM_RUN};

    // log2 of the tick count for a given timeout code
    function automatic int span_log2(input int base, input logic [1:0] code);
        return base + 2 * int'(code);
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter logic [7:0] ADDR_CFG = 8'hF0,
    parameter logic [7:0] ADDR_KEY = 8'hF1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       io_wr,
    input  logic [7:0] io_addr,
    input  logic [7:0] io_wdata,
    output wdt_cfg_t   cfg,
    output logic       running,
    output logic       kick
);

    logic cfg_wr;
    logic key_wr;
    logic mode_armed;

    assign cfg_wr = io_wr && (io_addr == ADDR_CFG) && (io_wdata[2:0] == CFG_MAGIC);
    assign key_wr = io_wr && (io_addr == ADDR_KEY);
    assign kick   = key_wr && (io_wdata == KEY_KICK);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= CFG_RESET;
            running    <= 1'b1;
            mode_armed <= 1'b0;
        end else if (cfg_wr) begin
            cfg.en     <= io_wdata[7];
            cfg.span   <= io_wdata[6:5];
            if (mode_armed) begin
                cfg.halt <= halt_mode_e'(io_wdata[4:3]);
            end
            mode_armed <= 1'b0;
            if (io_wdata[7]) begin
                running <= 1'b1;
            end
        end else if (key_wr) begin
            unique case (io_wdata)
                KEY_KICK: ;
                KEY_STOP: begin
                    if (!cfg.en) begin
                        running <= 1'b0;
                    end
                end
                KEY_MODE: mode_armed <= 1'b1;
                default:  mode_armed <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 16,
    localparam int CNT_W    = BASE_LOG2 + 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       running,
    input  logic       kick,
    input  logic       hold,
    input  logic [1:0] span,
    output logic       expire
);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] last_val;

    always_comb begin
        last_val = (CNT_W'(1) << span_log2(BASE_LOG2, span)) - CNT_W'(1);
    end

    assign expire = running && tick && !kick && !hold && (count >= last_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (hold || expire || kick || !running) begin
            count <= '0;
        end else if (tick) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int PULSE_LEN = 16,
    localparam int PW       = $clog2(PULSE_LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active
);

    logic [PW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (remain != '0) begin
            remain <= remain - PW'(1);
        end else if (fire) begin
            remain <= PW'(PULSE_LEN);
        end
    end

    assign active = (remain != '0);

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
    import wdt_pkg::*;
#(
    parameter int         BASE_LOG2 = 16,
    parameter int         PULSE_LEN = 16,
    parameter logic [7:0] ADDR_CFG  = 8'hF0,
    parameter logic [7:0] ADDR_KEY  = 8'hF1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       io_wr,
    input  logic [7:0] io_addr,
    input  logic [7:0] io_wdata,
    input  logic       tick,
    output logic       wdt_rst,
    output logic [1:0] halt_mode
);

    wdt_cfg_t cfg;
    logic     running;
    logic     kick;
    logic     expire;
    logic     pulse_on;

    wdt_regs #(
        .ADDR_CFG (ADDR_CFG),
        .ADDR_KEY (ADDR_KEY)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .cfg      (cfg),
        .running  (running),
        .kick     (kick)
    );

    wdt_count #(
        .BASE_LOG2 (BASE_LOG2)
    ) count_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .running (running),
        .kick    (kick),
        .hold    (pulse_on),
        .span    (cfg.span),
        .expire  (expire)
    );

    wdt_pulse #(
        .PULSE_LEN (PULSE_LEN)
    ) pulse_i (
        .clk    (clk),
        .rst    (rst),
        .fire   (expire),
        .active (pulse_on)
    );

    assign wdt_rst   = pulse_on;
    assign halt_mode = cfg.halt;

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
    parameter int         PULSE_LEN = 16,
    parameter logic [7:0] ADDR_CFG  = 8'hF0,
    parameter logic [7:0] ADDR_KEY  = 8'hF1,
    localparam int        HW        = $clog2(PULSE_LEN + 2)
) (
    input logic       clk,
    input logic       rst,
    input logic       io_wr,
    input logic [7:0] io_addr,
    input logic [7:0] io_wdata,
    input logic       tick,
    input logic       running,
    input logic       wdt_rst,
    input logic [1:0] halt_mode
);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
        end else if (wdt_rst) begin
            hi_cnt <= hi_cnt + HW'(1);
        end else begin
            hi_cnt <= '0;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!wdt_rst && halt_mode == 2'd3));

    // R10
    pulse_len_max_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> (hi_cnt < HW'(PULSE_LEN)));

    // R10
    pulse_len_exact_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wdt_rst) |-> (hi_cnt == HW'(PULSE_LEN)));

    // R4
    expire_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wdt_rst) |=> !wdt_rst);

    // R5
    kick_blocks_expire_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == ADDR_KEY && io_wdata == 8'h4E && !wdt_rst) |=> !wdt_rst);

    // R6
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && !wdt_rst) |=> !wdt_rst);

    // R8
    halt_only_by_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && io_addr == ADDR_CFG) |=> $stable(halt_mode));

    // R2
    bad_magic_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == ADDR_CFG && io_wdata[2:0] != 3'b011) |=> $stable(halt_mode));

endmodule

bind wdt_keyed_top wdt_keyed_chk #(
    .PULSE_LEN (PULSE_LEN),
    .ADDR_CFG  (ADDR_CFG),
    .ADDR_KEY  (ADDR_KEY)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .io_wr     (io_wr),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .tick      (tick),
    .running   (running),
    .wdt_rst   (wdt_rst),
    .halt_mode (halt_mode)
);

// File: tb/wdt_keyed_top_tb_top.sv
module wdt_keyed_top_tb_top;

    localparam int BASE  = 4;
    localparam int PLEN  = 16;
    localparam logic [7:0] A_CFG = 8'hF0;
    localparam logic [7:0] A_KEY = 8'hF1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_wr = 1'b0;
    logic [7:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic       tick = 1'b0;
    logic       wdt_rst;
    logic [1:0] halt_mode;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;

    // reference state
    int m_en, m_run, m_span, m_halt, m_arm, m_cnt, m_pulse;

    always #2 clk = ~clk;

    wdt_keyed_top #(
        .BASE_LOG2 (BASE),
        .PULSE_LEN (PLEN)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .io_wr     (io_wr),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .tick      (tick),
        .wdt_rst   (wdt_rst),
        .halt_mode (halt_mode)
    );

    function automatic int span_ticks(input int code);
        return 1 << (BASE + 2 * code);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_en = 1; m_run = 1; m_span = 3; m_halt = 3;
        m_arm = 0; m_cnt = 0; m_pulse = 0;
    endtask

    task automatic model_step(input bit wr, input logic [7:0] a, input logic [7:0] d, input bit tk);
        bit kick_now;
        bit cfg_ok;
        kick_now = wr && a == A_KEY && d == 8'h4E;
        cfg_ok   = wr && a == A_CFG && d[2:0] == 3'b011;
        if (m_pulse > 0) begin
            m_pulse--; m_cnt = 0;
        end else if (m_run != 0 && tk && !kick_now && m_cnt >= span_ticks(m_span) - 1) begin
            m_pulse = PLEN; m_cnt = 0;
        end else if (kick_now || m_run == 0) begin
            m_cnt = 0;
        end else if (tk) begin
            m_cnt++;
        end
        if (cfg_ok) begin
            m_en = int'(d[7]); m_span = int'(d[6:5]);
            if (m_arm != 0) m_halt = int'(d[4:3]);
            m_arm = 0;
            if (d[7]) m_run = 1;
        end else if (wr && a == A_KEY) begin
            if (d == 8'hB1) begin
                if (m_en == 0) m_run = 0;
            end else if (d == 8'hDB) begin
                m_arm = 1;
            end else if (d != 8'h4E) begin
                m_arm = 0;
            end
        end
    endtask

    task automatic cyc(input bit wr, input logic [7:0] a, input logic [7:0] d, input bit tk);
        io_wr = wr; io_addr = a; io_wdata = d; tick = tk;
        @(posedge clk);
        model_step(wr, a, d, tk);
        @(negedge clk);
        io_wr = 1'b0; tick = 1'b0;
        chk(wdt_rst == (m_pulse > 0), "R3 wdt_rst vs model", int'(wdt_rst), int'(m_pulse > 0));
        chk(int'(halt_mode) == m_halt, "R8 halt_mode vs model", int'(halt_mode), m_halt);
    endtask

    task automatic wr_cfg(input logic [7:0] d); cyc(1'b1, A_CFG, d, 1'b0); endtask
    task automatic wr_key(input logic [7:0] d); cyc(1'b1, A_KEY, d, 1'b0); endtask
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 8'h00, 1'b1);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 8'h00, 1'b0);
    endtask
    task automatic pulse_len(output int n);
        n = 1;
        while (wdt_rst && n < 40) begin
            idle(1);
            if (wdt_rst) n++;
        end
    endtask

    initial begin : watchdog
        while (cyc_cnt < 200000) begin
            @(posedge clk);
            cyc_cnt++;
        end
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc_cnt, 200000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int n;
        void'($urandom(32'd20517));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(!wdt_rst, "R1 wdt_rst after reset", int'(wdt_rst), 0);
        chk(halt_mode == 2'd3, "R1 halt_mode after reset", int'(halt_mode), 3);
        // R1 R3 default code 3
        ticks(span_ticks(3) - 1);
        chk(!wdt_rst, "R1 no expiry before code-3 span", int'(wdt_rst), 0);
        ticks(1);
        chk(wdt_rst, "R3 expiry at code-3 span", int'(wdt_rst), 1);
        pulse_len(n);
        chk(n == PLEN, "R10 pulse length", n, PLEN);

        // R5 restart key
        wr_key(8'h4E); wr_cfg(8'h9B);
        ticks(10); wr_key(8'h4E);
        ticks(15);
        chk(!wdt_rst, "R5 restart key reset the count", int'(wdt_rst), 0);
        ticks(1);
        chk(wdt_rst, "R3 expiry at code-0 span", int'(wdt_rst), 1);
        wr_key(8'h4E);
        pulse_len(n);
        chk(n == PLEN - 1, "R10 key during pulse does not extend it", n, PLEN - 1);

        // R4 no tick no progress
        idle(100);
        chk(!wdt_rst, "R4 idle without tick", int'(wdt_rst), 0);
        ticks(16);
        chk(wdt_rst, "R4 expiry after 16 ticks", int'(wdt_rst), 1);
        pulse_len(n);

        // R6 two-step stop
        wr_cfg(8'h1B);
        ticks(16);
        chk(wdt_rst, "R6 enable clear alone keeps running", int'(wdt_rst), 1);
        pulse_len(n);
        wr_key(8'hB1);
        ticks(100);
        chk(!wdt_rst, "R6 stopped after stop key", int'(wdt_rst), 0);
        // R7 restart from zero
        wr_cfg(8'h9B);
        ticks(15);
        chk(!wdt_rst, "R7 started from zero", int'(wdt_rst), 0);
        ticks(1);
        chk(wdt_rst, "R7 expiry after restart", int'(wdt_rst), 1);
        pulse_len(n);
        wr_key(8'h4E); wr_key(8'hB1);
        ticks(16);
        chk(wdt_rst, "R6 stop key ignored while enabled", int'(wdt_rst), 1);
        pulse_len(n);

        // R11 other address
        wr_cfg(8'h1B);
        cyc(1'b1, 8'hF2, 8'hB1, 1'b0);
        ticks(16);
        chk(wdt_rst, "R11 stop key at wrong address ignored", int'(wdt_rst), 1);
        pulse_len(n);
        wr_cfg(8'h9B);

        // R2 magic field and period select
        wr_key(8'h4E);
        cyc(1'b1, A_CFG, 8'h7A, 1'b0);
        ticks(16);
        chk(wdt_rst, "R2 bad magic write ignored", int'(wdt_rst), 1);
        pulse_len(n);
        wr_cfg(8'hBB); wr_key(8'h4E);
        ticks(63);
        chk(!wdt_rst, "R2 code-1 span not yet done", int'(wdt_rst), 0);
        ticks(1);
        chk(wdt_rst, "R2 code-1 span expiry", int'(wdt_rst), 1);
        pulse_len(n);
        wr_cfg(8'h9B);

        // R8 halt mode authorization
        wr_cfg(8'h83);
        chk(halt_mode == 2'd3, "R8 unauthorized halt change", int'(halt_mode), 3);
        wr_key(8'hDB); wr_cfg(8'h8B);
        chk(halt_mode == 2'd1, "R8 authorized halt change", int'(halt_mode), 1);
        wr_cfg(8'h93);
        chk(halt_mode == 2'd1, "R8 authorization is one-shot", int'(halt_mode), 1);
        // R9 foreign byte cancels, keys keep it
        wr_key(8'hDB); wr_key(8'h55); wr_cfg(8'h93);
        chk(halt_mode == 2'd1, "R9 foreign byte cancels authorization", int'(halt_mode), 1);
        wr_key(8'hDB); wr_key(8'h4E); wr_cfg(8'h83);
        chk(halt_mode == 2'd0, "R9 restart key keeps authorization", int'(halt_mode), 0);

        // random phase, compared against the model every cycle
        for (int i = 0; i < 20000; i++) begin
            int r;
            logic [7:0] d;
            bit tk;
            r  = int'($urandom % 100);
            tk = ($urandom % 10) < 7;
            d  = 8'($urandom);
            if (r < 6) begin
                if (($urandom % 4) != 0) d[2:0] = 3'b011;
                if (($urandom % 3) != 0) d[6:5] = 2'($urandom % 2);
                cyc(1'b1, A_CFG, d, tk);
            end else if (r < 14) begin
                case ($urandom % 5)
                    0: d = 8'h4E;
                    1: d = 8'hB1;
                    2: d = 8'hDB;
                    default: ;
                endcase
                cyc(1'b1, A_KEY, d, tk);
            end else if (r < 16) begin
                cyc(1'b1, 8'($urandom % 240), d, tk);
            end else begin
                cyc(1'b0, 8'h00, 8'h00, tk);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule